// File: doc/BRIEF.md
# Dual-CPU Slab Address Decoder with Fault Redirection

Two 68000-class processors share one memory system. Each has its own copy of the address decoder and its own private ROM. Each decoder splits the 24-bit address into eight 2 MB slabs. It sends every access to one of four targets: shared RAM, board resources, private ROM or a stack window. In the stack window the second processor sees the addresses mirrored, so the two stacks grow toward each other through the same physical RAM. After reset, each processor sees its ROM at slab zero. It keeps seeing it there until it writes a clear bit to the control word.

A bound register, loaded during boot, limits how far into shared RAM either processor may reach. An access at or above the bound is refused in the same cycle with a bus error. The offending processor is then held halted, and its companion receives a level-7 interrupt so that it can repair the fault. The companion ends the halt by writing a release bit. When both processors fault in the same cycle, processor A wins. A fault raised while the companion is already halted is deferred. In both cases the deferred fault takes effect once the companion is released, so no two processors are ever halted at the same time.

Top module: `dual_cpu_decode`

## Requirements
- R1: Address bits 23:21 select the slab. Slabs 0–3 assert sel bit 0 (RAM), slabs 4–5 assert sel bit 1 (board), slab 6 asserts sel bit 2 (ROM) and slab 7 asserts sel bit 3 (stack). sel is zero when the strobe is low, and at most one bit is ever set.
- R2: For RAM, board and ROM accesses without overlay, and for CPU A stack accesses, the physical address equals the CPU address.
- R3: After reset, a slab-0 access by either CPU selects ROM (sel 4'b0100) with physical address {3'b110, addr[20:0]}. A write with data bit 0 set to the control word at 0x800000 ends the overlay for the writing CPU only, from the next cycle on.
- R4: In the stack slab, CPU B's physical address has bits 20:1 inverted and bits 23:21 and 0 unchanged.
- R5: A write to 0x800002 loads the bound from data bits 7:0, effective the next cycle; the reset value is 0x80. A RAM access whose bits 23:16 are at or above the bound raises berr in the same cycle and leaves sel at zero.
- R6: From the cycle after a fault, the offender's halt and berr stay high, and the companion's irq7 is high.
- R7: While a CPU is halted, its strobe is ignored: sel stays zero and its writes have no effect.
- R8: When the companion writes data bit 1 set to the control word, the halted CPU's halt, berr and the companion's irq7 drop in the next cycle.
- R9: When both CPUs fault in the same cycle, only A halts and only B gets irq7. B's fault is deferred, and B halts (with irq7 to A) in the cycle after B releases A.
- R10: A fault by a CPU while its companion is halted is deferred in the same way. It takes effect in the cycle after the halted CPU is released, and both CPUs are never halted together.
- R11: After reset, halt, irq7 and berr are low on both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| aStrobe | input | 1 | CPU A access valid |
| aWrite | input | 1 | CPU A write |
| aAddr | input | 24 | CPU A byte address |
| aWdata | input | 16 | CPU A write data |
| bStrobe | input | 1 | CPU B access valid |
| bWrite | input | 1 | CPU B write |
| bAddr | input | 24 | CPU B byte address |
| bWdata | input | 16 | CPU B write data |
| aSel | output | 4 | CPU A one-hot target select |
| aPhys | output | 24 | CPU A physical address |
| aBerr | output | 1 | CPU A bus error |
| aHalt | output | 1 | CPU A halt |
| aIrq7 | output | 1 | Level-7 interrupt to CPU A |
| bSel | output | 4 | CPU B one-hot target select |
| bPhys | output | 24 | CPU B physical address |
| bBerr | output | 1 | CPU B bus error |
| bHalt | output | 1 | CPU B halt |
| bIrq7 | output | 1 | Level-7 interrupt to CPU B |

## Verification
The bench builds the block with its default parameters: the control word at 0x800000, the bound word at 0x800002 and a reset bound of 0x80. With these values no RAM address can fault until the bound is lowered. The bench therefore loads a bound of 0x40, so that slabs 2 and 3 become out of range while slabs 0 and 1 stay legal. This makes it possible to drive both a single fault and two simultaneous faults. It also drives a fault while the companion is halted, and then walks the deferred-release chain in both directions.

// File: rtl/dual_cpu_decode_pkg.sv
package dual_cpu_decode_pkg;
  localparam int ADDR_W  = 24;
  localparam int DATA_W  = 16;
  localparam int BOUND_W = 8;
  localparam int SLAB_W  = 3;
  localparam int SLAB_LSB = ADDR_W - SLAB_W;
  localparam int SLABS   = 1 << SLAB_W;

  typedef enum logic [1:0] {TGT_RAM = 2'd0, TGT_BOARD = 2'd1, TGT_ROM = 2'd2, TGT_STACK = 2'd3} target_e;

  // control -> datapath
  typedef struct packed {
    logic               overlay;
    logic               halted;
    logic [BOUND_W-1:0] bound;
  } ctl_to_path_t;

  // datapath -> control
  typedef struct packed {
    logic               faultReq;
    logic               ovlClr;
    logic               relOther;
    logic               boundWr;
    logic [BOUND_W-1:0] boundVal;
  } path_to_ctl_t;
endpackage

// File: rtl/slab_decode_path.sv
module slab_decode_path
  import dual_cpu_decode_pkg::*;
#(
  parameter bit                MIRROR     = 1'b0,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 24'h800000,
  parameter logic [ADDR_W-1:0] BOUND_ADDR = 24'h800002,
  parameter logic [SLAB_W-1:0] ROM_SLAB   = 3'd6
) (
  input  logic              strobe,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  ctl_to_path_t      ctl,
  output path_to_ctl_t      toCtl,
  output logic [3:0]        sel,
  output logic [ADDR_W-1:0] phys
);
  logic [SLAB_W-1:0] slab;
  logic [SLABS-1:0]  slabHot;
  logic              active, ramHit, beyond, ctrlHit;
  target_e           tgt;
  logic [3:0]        tgtHot;

  assign slab   = addr[ADDR_W-1 -: SLAB_W];
  assign active = strobe && !ctl.halted;

  // 3-to-8 slab decode
  always_comb begin
    slabHot = '0;
    slabHot[slab] = 1'b1;
  end

  always_comb begin
    if (slabHot[0] && ctl.overlay)   tgt = TGT_ROM;
    else if (|slabHot[3:0])          tgt = TGT_RAM;
    else if (|slabHot[5:4])          tgt = TGT_BOARD;
    else if (slabHot[ROM_SLAB])      tgt = TGT_ROM;
    else                             tgt = TGT_STACK;
  end

  always_comb begin
    tgtHot = '0;
    tgtHot[tgt] = 1'b1;
  end

  assign ramHit = (tgt == TGT_RAM);
  assign beyond = addr[ADDR_W-1 -: BOUND_W] >= ctl.bound;

  always_comb begin
    phys = addr;
    if (tgt == TGT_ROM)
      phys = {ROM_SLAB, addr[SLAB_LSB-1:0]};
    else if (tgt == TGT_STACK && MIRROR)
      phys = {addr[ADDR_W-1 -: SLAB_W], ~addr[SLAB_LSB-1:1], addr[0]};
  end

  assign ctrlHit        = active && write && (addr == CTRL_ADDR);
  assign toCtl.faultReq = active && ramHit && beyond;
  assign toCtl.ovlClr   = ctrlHit && wdata[0];
  assign toCtl.relOther = ctrlHit && wdata[1];
  assign toCtl.boundWr  = active && write && (addr == BOUND_ADDR);
  assign toCtl.boundVal = wdata[BOUND_W-1:0];

  assign sel = (active && !toCtl.faultReq) ? tgtHot : 4'b0000;
endmodule

// File: rtl/fault_ctl.sv
module fault_ctl
  import dual_cpu_decode_pkg::*;
#(
  parameter logic [BOUND_W-1:0] BOUND_RESET = 8'h80
) (
  input  logic         clk,
  input  logic         rstN,
  input  path_to_ctl_t fromA,
  input  path_to_ctl_t fromB,
  output ctl_to_path_t toA,
  output ctl_to_path_t toB,
  output logic         faultA,
  output logic         faultB
);
  logic               pendA, pendB, ovlA, ovlB;
  logic [BOUND_W-1:0] bound;
  logic               relA, relB, clrA, clrB;
  logic               setA, setB, pendInA, pendInB;

  assign relA = fromB.relOther;   // B frees A
  assign relB = fromA.relOther;   // A frees B
  assign clrA = faultA && relA;
  assign clrB = faultB && relB;

  // A wins a tie; a fault against a halted companion waits
  assign setA    = fromA.faultReq && !faultB;
  assign pendInA = fromA.faultReq && faultB;
  assign setB    = fromB.faultReq && !faultA && !fromA.faultReq;
  assign pendInB = fromB.faultReq && (faultA || fromA.faultReq);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultA <= 1'b0;
      faultB <= 1'b0;
      pendA  <= 1'b0;
      pendB  <= 1'b0;
      ovlA   <= 1'b1;
      ovlB   <= 1'b1;
      bound  <= BOUND_RESET;
    end else begin
      faultA <= setA || (clrB && pendA) || (faultA && !relA);
      faultB <= setB || (clrA && pendB) || (faultB && !relB);
      pendA  <= (pendA && !clrB) || pendInA;
      pendB  <= (pendB && !clrA) || pendInB;
      if (fromA.ovlClr) ovlA <= 1'b0;
      if (fromB.ovlClr) ovlB <= 1'b0;
      if (fromA.boundWr)      bound <= fromA.boundVal;
      else if (fromB.boundWr) bound <= fromB.boundVal;
    end
  end

  assign toA = '{overlay: ovlA, halted: faultA, bound: bound};
  assign toB = '{overlay: ovlB, halted: faultB, bound: bound};
endmodule

// File: rtl/dual_cpu_decode.sv
module dual_cpu_decode
  import dual_cpu_decode_pkg::*;
#(
  parameter logic [ADDR_W-1:0]  CTRL_ADDR   = 24'h800000,
  parameter logic [ADDR_W-1:0]  BOUND_ADDR  = 24'h800002,
  parameter logic [BOUND_W-1:0] BOUND_RESET = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aStrobe,
  input  logic              aWrite,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWdata,
  input  logic              bStrobe,
  input  logic              bWrite,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWdata,
  output logic [3:0]        aSel,
  output logic [ADDR_W-1:0] aPhys,
  output logic              aBerr,
  output logic              aHalt,
  output logic              aIrq7,
  output logic [3:0]        bSel,
  output logic [ADDR_W-1:0] bPhys,
  output logic              bBerr,
  output logic              bHalt,
  output logic              bIrq7
);
  ctl_to_path_t ctlPath [2];
  path_to_ctl_t pathCtl [2];
  logic         strobeV [2];
  logic         writeV  [2];
  logic [ADDR_W-1:0] addrV  [2];
  logic [DATA_W-1:0] wdataV [2];
  logic [3:0]        selV   [2];
  logic [ADDR_W-1:0] physV  [2];
  logic faultA, faultB;

  assign strobeV = '{aStrobe, bStrobe};
  assign writeV  = '{aWrite, bWrite};
  assign addrV   = '{aAddr, bAddr};
  assign wdataV  = '{aWdata, bWdata};

  for (genvar i = 0; i < 2; i++) begin : g_cpu
    slab_decode_path #(
      .MIRROR(i == 1), .CTRL_ADDR(CTRL_ADDR), .BOUND_ADDR(BOUND_ADDR)
    ) u_path (
      .strobe(strobeV[i]), .write(writeV[i]), .addr(addrV[i]), .wdata(wdataV[i]),
      .ctl(ctlPath[i]), .toCtl(pathCtl[i]), .sel(selV[i]), .phys(physV[i])
    );
  end

  fault_ctl #(.BOUND_RESET(BOUND_RESET)) u_ctl (
    .clk(clk), .rstN(rstN), .fromA(pathCtl[0]), .fromB(pathCtl[1]),
    .toA(ctlPath[0]), .toB(ctlPath[1]), .faultA(faultA), .faultB(faultB)
  );

  assign aSel  = selV[0];
  assign bSel  = selV[1];
  assign aPhys = physV[0];
  assign bPhys = physV[1];
  assign aHalt = faultA;
  assign bHalt = faultB;
  assign aBerr = faultA || pathCtl[0].faultReq;
  assign bBerr = faultB || pathCtl[1].faultReq;
  assign bIrq7 = faultA;
  assign aIrq7 = faultB;
endmodule

// File: rtl/dual_cpu_decode_chk.sv
module dual_cpu_decode_chk #(
  parameter logic [23:0] CTRL_ADDR = 24'h800000
) (
  input logic        clk,
  input logic        rstN,
  input logic        aStrobe,
  input logic        aWrite,
  input logic [23:0] aAddr,
  input logic [15:0] aWdata,
  input logic        bStrobe,
  input logic        bWrite,
  input logic [23:0] bAddr,
  input logic [15:0] bWdata,
  input logic [3:0]  aSel,
  input logic [3:0]  bSel,
  input logic        aBerr,
  input logic        bBerr,
  input logic        aHalt,
  input logic        bHalt,
  input logic        aIrq7,
  input logic        bIrq7
);
  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(aSel) && $onehot0(bSel));
  // R6
  fault_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aBerr && !aHalt && !bHalt) |=> aHalt);
  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aHalt |-> bIrq7) and (bHalt |-> aIrq7));
  // R7
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aHalt |-> aSel == 4'b0000) and (bHalt |-> bSel == 4'b0000));
  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aHalt && !(bStrobe && bWrite && bAddr == CTRL_ADDR && bWdata[1])) |=> aHalt);
  // R10
  never_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(aHalt && bHalt));
  // R9
  irq_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({aIrq7, bIrq7}) <= 1);
endmodule

bind dual_cpu_decode dual_cpu_decode_chk #(.CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .aStrobe(aStrobe), .aWrite(aWrite), .aAddr(aAddr),
  .aWdata(aWdata), .bStrobe(bStrobe), .bWrite(bWrite), .bAddr(bAddr), .bWdata(bWdata),
  .aSel(aSel), .bSel(bSel), .aBerr(aBerr), .bBerr(bBerr), .aHalt(aHalt), .bHalt(bHalt),
  .aIrq7(aIrq7), .bIrq7(bIrq7)
);

// File: tb/test_dual_cpu_decode.sv
module test_dual_cpu_decode;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aStrobe = 0, aWrite = 0, bStrobe = 0, bWrite = 0;
  logic [23:0] aAddr = '0, bAddr = '0;
  logic [15:0] aWdata = '0, bWdata = '0;
  logic [3:0]  aSel, bSel;
  logic [23:0] aPhys, bPhys;
  logic aBerr, aHalt, aIrq7, bBerr, bHalt, bIrq7;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_cpu_decode i_dual_cpu_decode (.*);

  typedef struct packed {
    logic        isB;
    logic [23:0] addr;
    logic [3:0]  sel;
    logic [23:0] phys;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{1'b0, 24'h000000, 4'b0001, 24'h000000},
    '{1'b0, 24'h7FFFFE, 4'b0001, 24'h7FFFFE},
    '{1'b0, 24'h800010, 4'b0010, 24'h800010},
    '{1'b0, 24'hBFFFFE, 4'b0010, 24'hBFFFFE},
    '{1'b0, 24'hC00000, 4'b0100, 24'hC00000},
    '{1'b0, 24'hDFFFFE, 4'b0100, 24'hDFFFFE},
    '{1'b0, 24'hE00000, 4'b1000, 24'hE00000},
    '{1'b0, 24'hFFFFFE, 4'b1000, 24'hFFFFFE},
    '{1'b1, 24'h3A0004, 4'b0001, 24'h3A0004},
    '{1'b1, 24'hA00000, 4'b0010, 24'hA00000},
    '{1'b1, 24'hD00000, 4'b0100, 24'hD00000},
    '{1'b1, 24'hE00000, 4'b1000, 24'hFFFFFE},
    '{1'b1, 24'hFFFFFE, 4'b1000, 24'hE00000},
    '{1'b1, 24'hE12344, 4'b1000, 24'hFEDCBA}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    aStrobe = 0; aWrite = 0; bStrobe = 0; bWrite = 0;
  endtask

  task automatic accA(input logic wr, input logic [23:0] ad, input logic [15:0] d);
    aStrobe = 1; aWrite = wr; aAddr = ad; aWdata = d;
  endtask

  task automatic accB(input logic wr, input logic [23:0] ad, input logic [15:0] d);
    bStrobe = 1; bWrite = wr; bAddr = ad; bWdata = d;
  endtask

  task automatic nextCycle();
    @(negedge clk); idle(); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    check("R11 halt/irq/berr", {aHalt, aIrq7, aBerr, bHalt, bIrq7, bBerr}, 0);
    check("R1 idle sel", {aSel, bSel}, 0);
    @(negedge clk); rstN = 1; #1;

    // R3 overlay at reset
    accA(0, 24'h000100, 0); accB(0, 24'h000100, 0); #1;
    check("R3 A overlay sel", aSel, 4'b0100);
    check("R3 A overlay phys", aPhys, 24'hC00100);
    check("R3 B overlay sel", bSel, 4'b0100);
    nextCycle();
    accA(1, 24'h800000, 16'h0001); #1;
    check("R1 ctrl write is board", aSel, 4'b0010);
    nextCycle();
    accA(0, 24'h000100, 0); accB(0, 24'h000100, 0); #1;
    check("R3 A overlay cleared", aSel, 4'b0001);
    check("R3 A phys after clear", aPhys, 24'h000100);
    check("R3 B overlay untouched", bSel, 4'b0100);
    nextCycle();
    accB(1, 24'h800000, 16'h0001);
    nextCycle();

    // R1 R2 R4 table walk
    for (int k = 0; k < 14; k++) begin
      @(negedge clk); idle();
      if (VECS[k].isB) accB(0, VECS[k].addr, 0); else accA(0, VECS[k].addr, 0);
      #1;
      if (VECS[k].isB) begin
        check("R1 B sel", bSel, VECS[k].sel);
        check("R4 B phys", bPhys, VECS[k].phys);
      end else begin
        check("R1 A sel", aSel, VECS[k].sel);
        check("R2 A phys", aPhys, VECS[k].phys);
      end
    end
    nextCycle();
    check("R1 no strobe", {aSel, bSel}, 0);

    // R5 default bound passes top RAM
    accA(0, 24'h7FFFFE, 0); #1;
    check("R5 reset bound no berr", aBerr, 1'b0);
    nextCycle();
    accA(1, 24'h800002, 16'h0040);
    nextCycle();
    accA(0, 24'h3FFFFE, 0); #1;
    check("R5 below bound", {aSel, aBerr}, {4'b0001, 1'b0});
    nextCycle();
    accB(0, 24'h400000, 0); #1;
    check("R5 at bound berr", {bSel, bBerr}, {4'b0000, 1'b1});
    nextCycle();
    check("R6 after fault", {bHalt, bBerr, aIrq7, bIrq7, aHalt}, 5'b11100);
    // R7 halted B ignored, including a control write
    accB(1, 24'h800000, 16'h0002); #1;
    check("R7 halted B sel", bSel, 4'b0000);
    nextCycle();
    check("R7 halted B write ignored", {aHalt, bHalt}, 2'b01);
    // R8 release
    accA(1, 24'h800000, 16'h0002);
    nextCycle();
    check("R8 released", {bHalt, bBerr, aIrq7}, 3'b000);

    // R9 simultaneous fault
    accA(0, 24'h500000, 0); accB(0, 24'h500000, 0); #1;
    check("R9 both berr", {aBerr, bBerr}, 2'b11);
    nextCycle();
    check("R9 A wins", {aHalt, bHalt, bIrq7, aIrq7}, 4'b1010);
    accB(1, 24'h800000, 16'h0002);
    nextCycle();
    check("R9 B deferred takes over", {aHalt, bHalt, bIrq7, aIrq7}, 4'b0101);
    accA(1, 24'h800000, 16'h0002);
    nextCycle();
    check("R9 chain done", {aHalt, bHalt, aIrq7, bIrq7}, 4'b0000);

    // R10 fault while companion halted
    accB(0, 24'h600000, 0);
    nextCycle();
    check("R10 B halted", bHalt, 1'b1);
    accA(0, 24'h600000, 0); #1;
    check("R10 A refused", {aBerr, aSel}, {1'b1, 4'b0000});
    nextCycle();
    check("R10 A deferred", {aHalt, bHalt}, 2'b01);
    accA(1, 24'h800000, 16'h0002);
    nextCycle();
    check("R10 A takes over", {aHalt, bHalt, bIrq7, aIrq7}, 4'b1010);
    accB(1, 24'h800000, 16'h0002);
    nextCycle();
    check("R10 chain done", {aHalt, bHalt, aIrq7, bIrq7}, 4'b0000);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule